// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Alternate-Function Takeover

This block is a single general-purpose I/O port of `WIDTH` pins (eight by default). A port output register is loaded over a simple strobe-based register bus, and its bits drive the pads. The pad input levels are gated, passed through a latch-then-flop synchronizer, and read back over the same bus. The output driver is treated as permanently enabled.

Each pin can be taken over by an alternate-function module through two per-pin override pairs:

- One pair replaces the value driven on the pad.
- The other pair decides whether the pin's digital input is enabled, regardless of sleep.

The gated input of every pin is also exported unsynchronized to the alternate functions. Any consumer of that export has to synchronize it itself.

The read and write strobes are shared by all pins of the port. The sleep input is shared across ports and disables digital inputs that have no override.

Top module: `gpio_alt_port`

## Requirements
- R1: When `pv_ovr_en_i[n]` is 1, `pad_out_o[n]` equals `pv_ovr_val_i[n]`, whatever the port register holds.
- R2: When `pv_ovr_en_i[n]` is 0, `pad_out_o[n]` equals bit n of the port register.
- R3: When `ie_ovr_en_i[n]` is 1, the input of pin n is enabled exactly when `ie_ovr_val_i[n]` is 1, whether or not `sleep_i` is high.
- R4: When `ie_ovr_en_i[n]` is 0, the input of pin n is enabled while `sleep_i` is 0 and disabled while `sleep_i` is 1. A disabled input presents 0, and an enabled input presents `pad_in_i[n]`.
- R5: A rising clock edge with `wr_port_i` high loads all port register bits from `wdata_i`. Without the strobe, the register holds its value.
- R6: The pin value read back is the gated input as it stood at the most recent rising clock edge. It passes through a latch that is transparent while the clock is low and a flop that captures on the rising edge.
- R7: `rdata_o` is combinational. It shows the synchronized pins when `rd_pin_i` is high, otherwise the port register when `rd_port_i` is high, otherwise 0. The pin read wins when both strobes are high.
- R8: While `rst_ni` is low, the port register and both synchronizer stages are 0. The reset is asynchronous.
- R9: `alt_di_o` carries the gated input with no register on the path, so it follows a change of `pad_in_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | I/O clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Sleep state; disables inputs that have no override |
| wr_port_i | input | 1 | Port register write strobe |
| rd_port_i | input | 1 | Port register read strobe |
| rd_pin_i | input | 1 | Synchronized pin read strobe |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | WIDTH | Read data |
| pv_ovr_en_i | input | WIDTH | Per-pin output value override enable |
| pv_ovr_val_i | input | WIDTH | Per-pin output override value |
| ie_ovr_en_i | input | WIDTH | Per-pin input enable override enable |
| ie_ovr_val_i | input | WIDTH | Per-pin input enable override value |
| pad_in_i | input | WIDTH | Pad-side input levels |
| pad_out_o | output | WIDTH | Values driven onto the pads |
| alt_di_o | output | WIDTH | Gated, unsynchronized input for alternate functions |

## Verification
The bench builds the port with the default `WIDTH` of 8. Each override field is driven as an independent random 8-bit vector, so within one cycle different pins sit in different override combinations. Every mix of override enable, override value, port bit and sleep state is therefore reached across the pins many times over. Directed steps cover the following:

- sleep with and without the input-enable override;
- both read strobes high together;
- a read straight after a write;
- a pad change read in the same cycle it occurs, which must still return the previous pin value.

// File: rtl/gpio_alt_pkg.sv
package gpio_alt_pkg;
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_PORT = 2'd1,
    RD_PIN  = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/gpio_out_sel.sv
module gpio_out_sel #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] port_q_i,
  input  logic [WIDTH-1:0] ovr_en_i,
  input  logic [WIDTH-1:0] ovr_val_i,
  output logic [WIDTH-1:0] pad_out_o
);
  for (genvar n = 0; n < WIDTH; n++) begin : g_pin
    assign pad_out_o[n] = ovr_en_i[n] ? ovr_val_i[n] : port_q_i[n];
  end
endmodule

// File: rtl/gpio_in_gate.sv
module gpio_in_gate #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] pad_in_i,
  input  logic             sleep_i,
  input  logic [WIDTH-1:0] ie_ovr_en_i,
  input  logic [WIDTH-1:0] ie_ovr_val_i,
  output logic [WIDTH-1:0] di_o
);
  logic [WIDTH-1:0] in_en;

  for (genvar n = 0; n < WIDTH; n++) begin : g_pin
    // override beats sleep
    assign in_en[n] = ie_ovr_en_i[n] ? ie_ovr_val_i[n] : ~sleep_i;
    assign di_o[n]  = pad_in_i[n] & in_en[n];
  end
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] ff_q;

  // first stage: open while the clock is low
  always_latch begin
    if (!rst_ni)      lat_q = '0;
    else if (!clk_i)  lat_q = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= lat_q;
  end

  assign q_o = ff_q;

  p_pin_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (q_o == $past(d_i)))
    else $error("pin synchronizer latency broken");
endmodule

// File: rtl/gpio_alt_port.sv
module gpio_alt_port
  import gpio_alt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_i,
  input  logic             wr_port_i,
  input  logic             rd_port_i,
  input  logic             rd_pin_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [WIDTH-1:0] pv_ovr_en_i,
  input  logic [WIDTH-1:0] pv_ovr_val_i,
  input  logic [WIDTH-1:0] ie_ovr_en_i,
  input  logic [WIDTH-1:0] ie_ovr_val_i,
  input  logic [WIDTH-1:0] pad_in_i,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] alt_di_o
);
  logic [WIDTH-1:0] port_q;
  logic [WIDTH-1:0] pin_q;
  logic [WIDTH-1:0] di;
  rd_sel_e          rd_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        port_q <= '0;
    else if (wr_port_i) port_q <= wdata_i;
  end

  gpio_out_sel #(.WIDTH(WIDTH)) u_out_sel (
    .port_q_i  (port_q),
    .ovr_en_i  (pv_ovr_en_i),
    .ovr_val_i (pv_ovr_val_i),
    .pad_out_o (pad_out_o)
  );

  gpio_in_gate #(.WIDTH(WIDTH)) u_in_gate (
    .pad_in_i     (pad_in_i),
    .sleep_i      (sleep_i),
    .ie_ovr_en_i  (ie_ovr_en_i),
    .ie_ovr_val_i (ie_ovr_val_i),
    .di_o         (di)
  );

  gpio_pin_sync #(.WIDTH(WIDTH)) u_pin_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (di),
    .q_o    (pin_q)
  );

  assign alt_di_o = di;

  always_comb begin
    if (rd_pin_i)       rd_sel = RD_PIN;
    else if (rd_port_i) rd_sel = RD_PORT;
    else                rd_sel = RD_NONE;
  end

  always_comb begin
    case (rd_sel)
      RD_PIN:  rdata_o = pin_q;
      RD_PORT: rdata_o = port_q;
      default: rdata_o = '0;
    endcase
  end

  p_out_override_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_out_o ^ pv_ovr_val_i) & pv_ovr_en_i) == '0)
    else $error("override value not on pad");

  p_out_port_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_out_o ^ port_q) & ~pv_ovr_en_i) == '0)
    else $error("port bit not on pad");

  p_sleep_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> ((alt_di_o & ~ie_ovr_en_i) == '0))
    else $error("input active in sleep without override");

  p_ie_forced_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((alt_di_o & ie_ovr_en_i & ~ie_ovr_val_i) == '0))
    else $error("overridden-off input not zero");

  p_port_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_port_i |=> (port_q == $past(wdata_i)))
    else $error("port write not loaded");

  p_port_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_port_i |=> $stable(port_q))
    else $error("port register changed without write");

  p_rdata_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_pin_i && !rd_port_i) |-> (rdata_o == '0))
    else $error("read bus not zero when idle");
endmodule

// File: tb/gpio_alt_port_tb.sv
`timescale 1ns/1ps
module gpio_alt_port_tb;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         sleep_i;
  logic         wr_port_i, rd_port_i, rd_pin_i;
  logic [W-1:0] wdata_i, rdata_o;
  logic [W-1:0] pv_ovr_en_i, pv_ovr_val_i, ie_ovr_en_i, ie_ovr_val_i;
  logic [W-1:0] pad_in_i, pad_out_o, alt_di_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] exp_port, exp_pin;

  always #2.5 clk_i = ~clk_i;

  gpio_alt_port #(.WIDTH(W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i),
    .wr_port_i(wr_port_i), .rd_port_i(rd_port_i), .rd_pin_i(rd_pin_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pv_ovr_en_i(pv_ovr_en_i), .pv_ovr_val_i(pv_ovr_val_i),
    .ie_ovr_en_i(ie_ovr_en_i), .ie_ovr_val_i(ie_ovr_val_i),
    .pad_in_i(pad_in_i), .pad_out_o(pad_out_o), .alt_di_o(alt_di_o)
  );

  function automatic logic [W-1:0] f_pad(logic [W-1:0] port, logic [W-1:0] en,
                                         logic [W-1:0] val);
    return (en & val) | (~en & port);
  endfunction

  function automatic logic [W-1:0] f_di(logic [W-1:0] pad, logic slp,
                                        logic [W-1:0] en, logic [W-1:0] val);
    return pad & ((en & val) | (~en & {W{~slp}}));
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // inputs set at a falling edge; check, then advance the model over the rising edge
  task automatic step();
    logic [W-1:0] exp_rd;
    #1;
    check(pv_ovr_en_i != 0 ? "R1 pad" : "R2 pad", pad_out_o,
          f_pad(exp_port, pv_ovr_en_i, pv_ovr_val_i));
    check(ie_ovr_en_i != 0 ? "R3 R9 alt_di" : "R4 R9 alt_di", alt_di_o,
          f_di(pad_in_i, sleep_i, ie_ovr_en_i, ie_ovr_val_i));
    exp_rd = rd_pin_i ? exp_pin : (rd_port_i ? exp_port : '0);
    check(rd_pin_i ? "R6 R7 pin read" : "R7 read", rdata_o, exp_rd);
    @(posedge clk_i);
    if (wr_port_i) exp_port = wdata_i;
    exp_pin = f_di(pad_in_i, sleep_i, ie_ovr_en_i, ie_ovr_val_i);
    @(negedge clk_i);
  endtask

  task automatic idle();
    wr_port_i = 0; rd_port_i = 0; rd_pin_i = 0;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_ni = 0; sleep_i = 0; idle();
    wdata_i = 8'hFF; pv_ovr_en_i = 0; pv_ovr_val_i = 0;
    ie_ovr_en_i = 0; ie_ovr_val_i = 0; pad_in_i = 8'hA5;
    exp_port = 0; exp_pin = 0;

    // R8: reset holds everything at zero, even under a write strobe
    repeat (2) @(negedge clk_i);
    wr_port_i = 1; rd_port_i = 1;
    @(negedge clk_i); #1;
    check("R8 port read in reset", rdata_o, 8'h00);
    check("R8 pad in reset", pad_out_o, 8'h00);
    rd_port_i = 0; rd_pin_i = 1; #1;
    check("R8 pin read in reset", rdata_o, 8'h00);
    @(negedge clk_i);
    idle(); rst_ni = 1;
    step();

    // R5 write then read back; R2 drives pads
    wr_port_i = 1; wdata_i = 8'h3C; step();
    idle(); rd_port_i = 1; step();
    // R1 override on some pins
    pv_ovr_en_i = 8'h0F; pv_ovr_val_i = 8'h05; step();
    // R6: pad change read in the same cycle returns the older value
    idle(); rd_pin_i = 1; pad_in_i = 8'h5A; step();
    step();
    // R7 both strobes: pin wins
    rd_port_i = 1; step();
    // R4 sleep without override blocks inputs
    idle(); sleep_i = 1; ie_ovr_en_i = 0; pad_in_i = 8'hFF; rd_pin_i = 1; step();
    step();
    // R3 override keeps inputs alive in sleep, and forces some off when awake
    ie_ovr_en_i = 8'hF0; ie_ovr_val_i = 8'h30; step();
    step();
    sleep_i = 0; step();
    step();
    // R9 same-cycle follow of pad
    pad_in_i = 8'h81; step();

    for (int i = 0; i < 600; i++) begin
      wr_port_i    = $urandom_range(0, 1);
      rd_port_i    = $urandom_range(0, 1);
      rd_pin_i     = $urandom_range(0, 1);
      sleep_i      = ($urandom_range(0, 3) == 0);
      wdata_i      = $urandom;
      pv_ovr_en_i  = $urandom;
      pv_ovr_val_i = $urandom;
      ie_ovr_en_i  = $urandom;
      ie_ovr_val_i = $urandom;
      pad_in_i     = $urandom;
      step();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule